// File: doc/BRIEF.md
# TDM Time-Slot Route Table

The block decides, slot by slot, which internal serial port a TDM frame is connected to. It holds two tables, one for the receive direction and one for the transmit direction. Each table is an ordered list of run-length entries. An entry names a number of consecutive slots and the port that owns them. A code of zero means that no port owns those slots.

A framer outside the block supplies a slot-start strobe and a frame-start strobe for each direction. A walker steps through the active table, one entry after another, starting at slot 0. It drives a registered one-hot enable to the owning port for the whole slot.

Software loads the tables through a plain write port. Each write lands in a shadow copy. The shadow copy becomes the active copy only at the next frame start, so a frame that is already running is never disturbed.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset, both enable vectors are zero. They stay zero on slot strobes until the first frame start.
- R2: An entry stores (number of slots − 1) in `cfg_cnt`, so the values 0..63 give runs of 1..64 slots. It stores the port code in the 3-bit `cfg_dst`. Code k in 1..5 drives enable bit k−1. Codes 0, 6 and 7 drive no enable.
- R3: Entries apply in index order to consecutive slots, starting with entry 0 at slot 0 of the frame.
- R4: Each enable vector has at most one bit set.
- R5: An enable changes only on the clock edge that samples a slot-start strobe. It holds its value until the next slot-start strobe.
- R6: Once the slots of a frame run past the entry whose index equals `cfg_last`, every further slot of that frame drives no enable.
- R7: A slot-start that comes together with frame-start restarts the walk at entry 0, even when the previous frame stopped partway through its table.
- R8: Entry writes and `cfg_last` writes go to a shadow copy. The shadow copy becomes active only at a frame start. Slots of the frame already running keep the previous table.
- R9: The receive and transmit sides have separate tables, separate strobes and separate `cfg_last` values. Activity on one side does not change the other side's enables.
- R10: The number of entries in use is `cfg_last`+1, from 1 up to the table depth of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_last_we | input | 1 | Write the index of the last valid entry |
| cfg_dir | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_addr | input | 6 | Entry index |
| cfg_cnt | input | 6 | Run length minus one |
| cfg_dst | input | 3 | Port code |
| cfg_last | input | 6 | Index of the last valid entry |
| rx_frame_start | input | 1 | Receive frame start, valid with rx_slot_start |
| rx_slot_start | input | 1 | Receive slot strobe, one cycle per slot |
| tx_frame_start | input | 1 | Transmit frame start, valid with tx_slot_start |
| tx_slot_start | input | 1 | Transmit slot strobe, one cycle per slot |
| rx_port_en | output | 5 | One-hot receive port enables |
| tx_port_en | output | 5 | One-hot transmit port enables |

## Verification
Each enable is due one clock edge after the cycle in which its slot strobe is high. The bench raises the strobes at a falling edge, clears them at the next falling edge and compares the enables at that same point. It then compares them once more a cycle later, with no strobe, to confirm that they held. Table writes are not checked directly. The bench keeps a mirror of both the shadow and active copies, and promotes the mirror only on the frame-start slot. A write made in the middle of a frame is therefore expected to show up only in the following frame.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int DST_W     = 3;
    localparam int NUM_PORTS = 5;

    function automatic logic [NUM_PORTS-1:0] dst_onehot(input logic [DST_W-1:0] d);
        logic [NUM_PORTS-1:0] r;
        r = '0;
        for (int k = 1; k <= NUM_PORTS; k++) begin
            if (d == DST_W'(k)) r[k-1] = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/tsr_table.sv
module tsr_table
    import tsr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 6,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int ENT_W = CNT_W + DST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [DST_W-1:0] wr_dst,
    input  logic             last_we,
    input  logic [IDX_W-1:0] last_val,
    input  logic             swap,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [DST_W-1:0] rd_dst,
    output logic [IDX_W-1:0] rd_last
);
    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] shadow;
        logic [DEPTH-1:0][ENT_W-1:0] active;
        logic [IDX_W-1:0]            last_sh;
        logic [IDX_W-1:0]            last_act;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [ENT_W-1:0] ent;

    always_comb begin
        tbl_d = tbl_q;
        if (swap) begin
            tbl_d.active   = tbl_q.shadow;
            tbl_d.last_act = tbl_q.last_sh;
        end
        if (wr_en)   tbl_d.shadow[wr_addr] = {wr_cnt, wr_dst};
        if (last_we) tbl_d.last_sh = last_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // on a swap the walker needs entry 0 of the table being promoted
    always_comb begin
        ent     = swap ? tbl_q.shadow[0] : tbl_q.active[rd_addr];
        rd_last = swap ? tbl_q.last_sh   : tbl_q.last_act;
        rd_cnt  = ent[ENT_W-1:DST_W];
        rd_dst  = ent[DST_W-1:0];
    end

    assert_active_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(tbl_q.active) && $stable(tbl_q.last_act));
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker
    import tsr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 6,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 slot_start,
    output logic                 swap,
    output logic [IDX_W-1:0]     rd_addr,
    input  logic [CNT_W-1:0]     rd_cnt,
    input  logic [DST_W-1:0]     rd_dst,
    input  logic [IDX_W-1:0]     rd_last,
    output logic [NUM_PORTS-1:0] port_en
);
    typedef struct packed {
        logic [IDX_W-1:0]     ptr;
        logic [CNT_W-1:0]     rem;
        logic [DST_W-1:0]     dst;
        logic                 done;
        logic [NUM_PORTS-1:0] en;
    } walk_t;

    walk_t st_d, st_q;

    assign swap    = frame_start && slot_start;
    assign rd_addr = swap ? '0 : IDX_W'(st_q.ptr + 1'b1);

    always_comb begin
        st_d = st_q;
        if (slot_start) begin
            if (frame_start) begin
                st_d.ptr  = '0;
                st_d.rem  = rd_cnt;
                st_d.dst  = rd_dst;
                st_d.done = 1'b0;
            end else if (st_q.done) begin
                st_d.dst = '0;
            end else if (st_q.rem != '0) begin
                st_d.rem = st_q.rem - 1'b1;
            end else if (st_q.ptr == rd_last) begin
                st_d.done = 1'b1;
                st_d.dst  = '0;
            end else begin
                st_d.ptr = IDX_W'(st_q.ptr + 1'b1);
                st_d.rem = rd_cnt;
                st_d.dst = rd_dst;
            end
            st_d.en = dst_onehot(st_d.dst);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign port_en = st_q.en;

    assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.en));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> $stable(st_q.en));
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && frame_start) |=> (st_q.ptr == '0) && !st_q.done);
    assert_past_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> st_q.en == '0);
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
    import tsr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 6,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_last_we,
    input  logic                 cfg_dir,
    input  logic [IDX_W-1:0]     cfg_addr,
    input  logic [CNT_W-1:0]     cfg_cnt,
    input  logic [DST_W-1:0]     cfg_dst,
    input  logic [IDX_W-1:0]     cfg_last,
    input  logic                 rx_frame_start,
    input  logic                 rx_slot_start,
    input  logic                 tx_frame_start,
    input  logic                 tx_slot_start,
    output logic [NUM_PORTS-1:0] rx_port_en,
    output logic [NUM_PORTS-1:0] tx_port_en
);
    localparam int NDIR = 2;

    logic [NDIR-1:0]                fs, ss;
    logic [NDIR-1:0][NUM_PORTS-1:0] en;

    assign fs = {tx_frame_start, rx_frame_start};
    assign ss = {tx_slot_start,  rx_slot_start};

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        logic             swap;
        logic [IDX_W-1:0] rd_addr;
        logic [CNT_W-1:0] rd_cnt;
        logic [DST_W-1:0] rd_dst;
        logic [IDX_W-1:0] rd_last;
        logic             sel;

        assign sel = (cfg_dir == 1'(g));

        tsr_table #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && sel),
            .wr_addr  (cfg_addr),
            .wr_cnt   (cfg_cnt),
            .wr_dst   (cfg_dst),
            .last_we  (cfg_last_we && sel),
            .last_val (cfg_last),
            .swap     (swap),
            .rd_addr  (rd_addr),
            .rd_cnt   (rd_cnt),
            .rd_dst   (rd_dst),
            .rd_last  (rd_last)
        );

        tsr_walker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_walker (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (fs[g]),
            .slot_start  (ss[g]),
            .swap        (swap),
            .rd_addr     (rd_addr),
            .rd_cnt      (rd_cnt),
            .rd_dst      (rd_dst),
            .rd_last     (rd_last),
            .port_en     (en[g])
        );
    end

    assign rx_port_en = en[0];
    assign tx_port_en = en[1];

    assert_rx_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_slot_start |=> $stable(rx_port_en));
    assert_tx_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_slot_start |=> $stable(tx_port_en));
endmodule

// File: tb/test_tdm_slot_router.sv
module test_tdm_slot_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_last_we = 0, cfg_dir = 0;
    logic [5:0] cfg_addr = 0, cfg_cnt = 0, cfg_last = 0;
    logic [2:0] cfg_dst = 0;
    logic rx_fs = 0, rx_ss = 0, tx_fs = 0, tx_ss = 0;
    logic [4:0] rx_en, tx_en;

    int n_vec = 0, n_bad = 0;
    int sh_cnt[2][64], sh_dst[2][64], sh_last[2];
    int ac_cnt[2][64], ac_dst[2][64], ac_last[2];
    int slot_idx[2];
    bit started[2];
    logic [4:0] exp_en[2];

    always #2.5 clk = ~clk;

    tdm_slot_router i_tdm_slot_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_last_we(cfg_last_we),
        .cfg_dir(cfg_dir), .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt), .cfg_dst(cfg_dst),
        .cfg_last(cfg_last), .rx_frame_start(rx_fs), .rx_slot_start(rx_ss),
        .tx_frame_start(tx_fs), .tx_slot_start(tx_ss),
        .rx_port_en(rx_en), .tx_port_en(tx_en));

    function automatic logic [4:0] onehot(int d);
        return (d >= 1 && d <= 5) ? 5'(1 << (d - 1)) : 5'd0;
    endfunction

    function automatic logic [4:0] model(int d, int s);
        int cum = 0;
        for (int i = 0; i <= ac_last[d]; i++) begin
            if (s < cum + ac_cnt[d][i] + 1) return onehot(ac_dst[d][i]);
            cum += ac_cnt[d][i] + 1;
        end
        return 5'd0;
    endfunction

    task automatic check(string req, logic [4:0] got, logic [4:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr_entry(int d, int a, int c, int t);
        @(negedge clk);
        cfg_we = 1; cfg_dir = 1'(d); cfg_addr = 6'(a); cfg_cnt = 6'(c); cfg_dst = 3'(t);
        @(negedge clk);
        cfg_we = 0;
        sh_cnt[d][a] = c; sh_dst[d][a] = t;
    endtask

    task automatic wr_last(int d, int l);
        @(negedge clk);
        cfg_last_we = 1; cfg_dir = 1'(d); cfg_last = 6'(l);
        @(negedge clk);
        cfg_last_we = 0;
        sh_last[d] = l;
    endtask

    // one slot: strobe, then check after the edge, then check hold a cycle later
    task automatic slot(string req, bit rx, bit tx, bit rxf, bit txf);
        bit act[2];
        bit frm[2];
        act[0] = rx; act[1] = tx; frm[0] = rxf; frm[1] = txf;
        @(negedge clk);
        rx_ss = rx; rx_fs = rx && rxf; tx_ss = tx; tx_fs = tx && txf;
        for (int d = 0; d < 2; d++) begin
            if (act[d]) begin
                if (frm[d]) begin
                    for (int i = 0; i < 64; i++) begin
                        ac_cnt[d][i] = sh_cnt[d][i]; ac_dst[d][i] = sh_dst[d][i];
                    end
                    ac_last[d] = sh_last[d];
                    started[d] = 1; slot_idx[d] = 0;
                end else begin
                    slot_idx[d]++;
                end
                exp_en[d] = started[d] ? model(d, slot_idx[d]) : 5'd0;
            end
        end
        @(negedge clk);
        rx_ss = 0; rx_fs = 0; tx_ss = 0; tx_fs = 0;
        check(req, rx_en, exp_en[0]);
        check(req, tx_en, exp_en[1]);
        @(negedge clk);
        check("R5", rx_en, exp_en[0]);
        check("R5", tx_en, exp_en[1]);
    endtask

    task automatic frame(string req, int n, bit rx, bit tx);
        for (int s = 0; s < n; s++) slot(req, rx, tx, s == 0, s == 0);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 64; i++) begin
                sh_cnt[d][i] = 0; sh_dst[d][i] = 0; ac_cnt[d][i] = 0; ac_dst[d][i] = 0;
            end
            sh_last[d] = 0; ac_last[d] = 0; started[d] = 0; slot_idx[d] = 0;
            exp_en[d] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", rx_en, 5'd0);
        check("R1", tx_en, 5'd0);
        // strobes before any frame start: still idle
        for (int s = 0; s < 3; s++) slot("R1", 1, 1, 0, 0);

        // run lengths 2,24,1,5 over 32 slots; transmit table differs
        wr_entry(0, 0, 1, 0); wr_entry(0, 1, 23, 3); wr_entry(0, 2, 0, 1); wr_entry(0, 3, 4, 2);
        wr_last(0, 3);
        wr_entry(1, 0, 4, 5); wr_entry(1, 1, 2, 0); wr_entry(1, 2, 9, 4);
        wr_last(1, 2);
        frame("R3", 34, 1, 1);
        // one side strobed alone: the other side must hold
        frame("R9", 12, 1, 0);
        frame("R9", 12, 0, 1);

        // arithmetic sweep of tables, codes 0..7, frames overrunning the table
        for (int p = 0; p < 10; p++) begin
            for (int d = 0; d < 2; d++) begin
                int q = p + 3 * d;
                int l = (q * 5 + 2) % 9;
                for (int i = 0; i <= l; i++) wr_entry(d, i, (i * 3 + q) % 4, (i + q) % 8);
                wr_last(d, l);
            end
            frame("R2 R3 R6", 30, 1, 1);
        end

        // full depth: 64 one-slot entries, then one 64-slot entry
        for (int i = 0; i < 64; i++) wr_entry(0, i, 0, (i % 5) + 1);
        wr_last(0, 63);
        wr_entry(1, 0, 63, 4);
        wr_last(1, 0);
        frame("R10 R6", 68, 1, 1);

        // writes mid-frame apply only at the next frame
        frame("R8", 10, 1, 1);
        wr_entry(0, 10, 5, 2); wr_entry(1, 0, 3, 1); wr_last(1, 2);
        wr_entry(1, 1, 1, 3); wr_entry(1, 2, 0, 5);
        for (int s = 0; s < 20; s++) slot("R8", 1, 1, 0, 0);
        frame("R8", 12, 1, 1);

        // short frames restart the walk partway through the table
        frame("R7", 3, 1, 1);
        frame("R7", 5, 1, 1);
        frame("R7", 8, 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule